// File: doc/BRIEF.md
# SPI Master/Slave Port

This block is a serial peripheral that sits on a simple synchronous register bus. It has two registers, selected by a one-bit address. Address 0 is the data register; address 1 is the control register. One shift engine serves both roles. As master, the block makes SCLK from the system clock at one of three rates. As slave, it follows an external SCLK and chip select, which it first brings into the system clock domain.

The serial format is fixed. SCLK idles low. Data is driven after the falling edge and sampled on the rising edge. Bit order and the use of chip select are both programmable. As master, a write to the data register starts an 8-bit transfer. The received byte is then read back from the same register. Status bits in the control register show write collisions and readiness for the next transfer. One interrupt flag marks the end of each byte.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0x00, the data register reads 0x00, `irq` is 0, `sclk_out` is 0 and `cs_n_out` is 1.
- R2: While the enable (control bit 4) is 0, no transfer runs: `sclk_out` stays 0, no interrupt is raised and the ready flag reads 0. A data register write is still stored and reads back.
- R3: The control register reads back as {0, mode[1:0] at bits 6:5, enable at 4, bit order at 3, chip-select use at 2, WCOL at 1, TRF at 0}. Writes to bits 7, 1 and 0 have no effect.
- R4: Mode 00, 01 and 10 select master with SCLK half-periods of 4, 16 and 64 system clocks. The interrupt flag appears exactly 16 half-periods after the clock edge that takes the data write.
- R5: In master mode, SCLK idles low and rises eight times per byte. Input data is sampled on each rising edge, and the output bit changes only on a falling edge.
- R6: Bit order flag 1 shifts the most significant bit first in both directions; flag 0 shifts the least significant bit first. After a transfer the data register holds the received byte in its normal bit positions.
- R7: In master mode with chip-select use set, `cs_n_out` is low for the whole byte; with it clear, `cs_n_out` stays high.
- R8: Mode 11 selects slave. SCLK, chip select and input data pass through two-flop synchronisers. The interrupt flag is set on the third system clock edge after the eighth falling SCLK edge.
- R9: In slave mode with chip-select use set, SCLK edges while `cs_n_in` is high are ignored. With it clear, the slave counts as always selected.
- R10: TRF reads 1 only when the block is enabled and no byte is in progress.
- R11: A data write during an active master transfer sets WCOL and leaves the transfer and its result unchanged. Reading the control register clears WCOL.
- R12: The interrupt flag is set at the end of each byte and cleared by any read or write of the data register. `irq` is the flag gated by `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 1 | 0 selects the data register, 1 the control register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq_en | input | 1 | Gates the interrupt flag onto `irq` |
| irq | output | 1 | End-of-byte interrupt |
| sclk_out | output | 1 | Master serial clock |
| cs_n_out | output | 1 | Master chip select, active low |
| sclk_in | input | 1 | Slave serial clock |
| cs_n_in | input | 1 | Slave chip select, active low |
| sdi | input | 1 | Serial data in, both roles |
| sdo | output | 1 | Serial data out, both roles |

## Verification
As master, the interrupt is due exactly 16 half-periods after the edge that takes the data write. The bench counts falling system clock edges from the end of that write until `irq` rises, and compares the count with 64, 256 or 1024. As slave, the flag is due on the third system clock edge after the final SCLK fall. The bench checks that it is still clear two clocks after the fall and set one clock later. Register reads are sampled combinationally in the middle of the access cycle. Serial outputs are captured on the SCLK edges themselves.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef enum logic [1:0] {
    RATE_FAST  = 2'b00,
    RATE_MID   = 2'b01,
    RATE_SLOW  = 2'b10,
    ROLE_SLAVE = 2'b11
  } spi_mode_e;

  typedef struct packed {
    logic [1:0] mode;
    logic       en;
    logic       msb_first;
    logic       cs_use;
  } spi_ctrl_t;

  localparam int unsigned CTRL_BITS = 7;
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int unsigned           W       = 3,
  parameter int unsigned           STAGES  = 2,
  parameter logic [W-1:0]          RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen #(
  parameter int unsigned HALF_FAST = 4,
  parameter int unsigned HALF_MID  = 16,
  parameter int unsigned HALF_SLOW = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       sclk,
  output logic       rise,
  output logic       fall
);
  localparam int unsigned MAX_AB = (HALF_FAST > HALF_MID) ? HALF_FAST : HALF_MID;
  localparam int unsigned MAX_H  = (MAX_AB > HALF_SLOW) ? MAX_AB : HALF_SLOW;
  localparam int unsigned CW     = (MAX_H > 2) ? $clog2(MAX_H) : 1;

  logic [CW-1:0] cnt_q, cnt_d, limit;
  logic          sclk_q, sclk_d, tick;

  always_comb begin
    case (rate)
      2'b00:   limit = CW'(HALF_FAST - 1);
      2'b01:   limit = CW'(HALF_MID - 1);
      default: limit = CW'(HALF_SLOW - 1);
    endcase
    tick   = run && (cnt_q == limit);
    cnt_d  = (!run || tick) ? '0 : cnt_q + 1'b1;
    sclk_d = !run ? 1'b0 : (tick ? ~sclk_q : sclk_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;
  assign rise = tick & ~sclk_q;
  assign fall = tick & sclk_q;

  a_r4_half_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && cnt_q != '0) |-> $stable(sclk_q));
  a_r5_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk_q);
endmodule

// File: rtl/spi_port_shift.sv
module spi_port_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          abort,
  input  logic          msb_first,
  input  logic          rise,
  input  logic          fall,
  input  logic          din,
  output logic [DW-1:0] shreg,
  output logic          dout,
  output logic          done,
  output logic          active
);
  localparam int unsigned CNTW = $clog2(DW + 1);
  localparam logic [CNTW-1:0] LAST = CNTW'(DW);

  logic [DW-1:0]   sh_q, sh_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            smp_q, smp_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    smp_d = smp_q;
    done  = 1'b0;
    if (load) begin
      sh_d  = load_val;
      cnt_d = '0;
    end else if (abort) begin
      cnt_d = '0;
    end else begin
      if (rise && cnt_q != LAST) begin
        smp_d = din;
        cnt_d = cnt_q + 1'b1;
      end
      if (fall && cnt_q != '0) begin
        sh_d = msb_first ? {sh_q[DW-2:0], smp_q} : {smp_q, sh_q[DW-1:1]};
        if (cnt_q == LAST) begin
          cnt_d = '0;
          done  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      smp_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      smp_q <= smp_d;
    end
  end

  assign shreg  = sh_q;
  assign dout   = msb_first ? sh_q[DW-1] : sh_q[0];
  assign active = (cnt_q != '0);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  a_r12_done_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt_q == '0));
  a_r5_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fall) && !$past(load)) |-> $stable(sh_q));
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned HALF_FAST   = 4,
  parameter int unsigned HALF_MID    = 16,
  parameter int unsigned HALF_SLOW   = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          irq_en,
  output logic          irq,
  output logic          sclk_out,
  output logic          cs_n_out,
  input  logic          sclk_in,
  input  logic          cs_n_in,
  input  logic          sdi,
  output logic          sdo
);
  logic [1:0] rst_pipe_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  spi_ctrl_t ctrl_q, ctrl_d;
  logic      wcol_q, wcol_d, flag_q, flag_d, mbusy_q, mbusy_d, sprev_q;

  logic       is_slave, wr_data, wr_ctrl, rd_ctrl, acc_data, start, collide;
  logic       s_sclk, s_csn, s_sdi, selected, s_rise, s_fall;
  logic       m_sclk, m_rise, m_fall;
  logic       e_rise, e_fall, e_din, e_load, e_abort, e_done, e_active;
  logic       trf;
  logic [DW-1:0] e_sh, ctrl_view;

  spi_port_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_sn),
    .d    ({sclk_in, cs_n_in, sdi}),
    .q    ({s_sclk, s_csn, s_sdi})
  );

  spi_port_clkgen #(.HALF_FAST(HALF_FAST), .HALF_MID(HALF_MID), .HALF_SLOW(HALF_SLOW)) u_clk (
    .clk  (clk),
    .rst_n(rst_sn),
    .run  (mbusy_q),
    .rate (ctrl_q.mode),
    .sclk (m_sclk),
    .rise (m_rise),
    .fall (m_fall)
  );

  spi_port_shift #(.DW(DW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sn),
    .load     (e_load),
    .load_val (bus_wdata),
    .abort    (e_abort),
    .msb_first(ctrl_q.msb_first),
    .rise     (e_rise),
    .fall     (e_fall),
    .din      (e_din),
    .shreg    (e_sh),
    .dout     (sdo),
    .done     (e_done),
    .active   (e_active)
  );

  always_comb begin
    is_slave = (ctrl_q.mode == ROLE_SLAVE);
    wr_data  = bus_sel && bus_wr && !bus_addr;
    wr_ctrl  = bus_sel && bus_wr && bus_addr;
    rd_ctrl  = bus_sel && !bus_wr && bus_addr;
    acc_data = bus_sel && !bus_addr;
    start    = wr_data && ctrl_q.en && !is_slave && !mbusy_q;
    collide  = wr_data && ctrl_q.en && !is_slave && mbusy_q;

    selected = !ctrl_q.cs_use || !s_csn;
    s_rise   = ctrl_q.en && is_slave && selected && s_sclk && !sprev_q;
    s_fall   = ctrl_q.en && is_slave && selected && !s_sclk && sprev_q;

    e_rise   = is_slave ? s_rise : m_rise;
    e_fall   = is_slave ? s_fall : m_fall;
    e_din    = is_slave ? s_sdi : sdi;
    e_load   = wr_data && (is_slave ? !e_active : !mbusy_q);
    e_abort  = !ctrl_q.en || (is_slave && !selected);

    trf = ctrl_q.en && (is_slave ? !e_active : !mbusy_q);

    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = bus_wdata[6:2];

    mbusy_d = mbusy_q;
    if (!ctrl_q.en || is_slave) mbusy_d = 1'b0;
    else if (start)             mbusy_d = 1'b1;
    else if (e_done)            mbusy_d = 1'b0;

    wcol_d = wcol_q;
    if (collide)      wcol_d = 1'b1;
    else if (rd_ctrl) wcol_d = 1'b0;

    flag_d = flag_q;
    if (e_done)        flag_d = 1'b1;
    else if (acc_data) flag_d = 1'b0;

    ctrl_view = '0;
    ctrl_view[CTRL_BITS-1:0] = {ctrl_q.mode, ctrl_q.en, ctrl_q.msb_first,
                                ctrl_q.cs_use, wcol_q, trf};
    bus_rdata = bus_addr ? ctrl_view : e_sh;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_q  <= '0;
      wcol_q  <= 1'b0;
      flag_q  <= 1'b0;
      mbusy_q <= 1'b0;
      sprev_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      wcol_q  <= wcol_d;
      flag_q  <= flag_d;
      mbusy_q <= mbusy_d;
      sprev_q <= s_sclk;
    end
  end

  assign irq      = flag_q & irq_en;
  assign sclk_out = m_sclk;
  assign cs_n_out = !(mbusy_q && ctrl_q.cs_use);

  a_r2_off_stops: assert property (@(posedge clk) disable iff (!rst_sn)
    !ctrl_q.en |=> !mbusy_q);
  a_r11_wcol_marks: assert property (@(posedge clk) disable iff (!rst_sn)
    collide |=> wcol_q);
  a_r12_flag_on_end: assert property (@(posedge clk) disable iff (!rst_sn)
    e_done |=> flag_q);
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_sn)
    (!mbusy_q && !$past(mbusy_q)) |-> !sclk_out);
endmodule

// File: tb/spi_port_test.sv
module spi_port_test;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, bus_sel, bus_wr, bus_addr, irq_en;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq, sclk_out, cs_n_out, sclk_in, cs_n_in, sdi, sdo;

  int n_chk = 0;
  int n_fail = 0;

  spi_port uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_en(irq_en), .irq(irq),
    .sclk_out(sclk_out), .cs_n_out(cs_n_out), .sclk_in(sclk_in), .cs_n_in(cs_n_in),
    .sdi(sdi), .sdo(sdo)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  function automatic logic [7:0] mk_ctrl(input logic [1:0] m, input logic en,
                                         input logic msb, input logic cs);
    return {1'b0, m, en, msb, cs, 2'b00};
  endfunction

  // Master transfer with a bench-side slave model; optional collision write.
  task automatic m_xfer(input logic [7:0] d, input logic [7:0] p, input int half,
                        input logic msb, input logic cs, input logic col);
    logic [7:0] cap, v;
    logic       cs_seen;
    int         k;
    cap = '0; cs_seen = 1'b1; k = 0;
    sdi = msb ? p[7] : p[0];
    bus_write(1'b0, d);
    fork
      begin
        for (int i = 0; i < 8; i++) begin
          @(posedge sclk_out);
          if (i == 0) cs_seen = cs_n_out;
          cap[msb ? 7 - i : i] = sdo;
          @(negedge sclk_out);
          if (i < 7) sdi = msb ? p[6 - i] : p[i + 1];
        end
      end
      begin
        while (!irq && k < 5000) begin
          @(negedge clk);
          k++;
        end
      end
      begin
        if (col) begin
          repeat (10) @(negedge clk);
          bus_write(1'b0, ~d);
          bus_read(1'b1, v);
          check("R11 wcol set on busy write", int'(v[1]), 1);
          check("R10 trf low while busy", int'(v[0]), 0);
        end
      end
    join
    check("R4 master byte duration", k, 16 * half);
    check("R6 master sent bits in order", int'(cap), int'(d));
    check("R7 chip select level", int'(cs_seen), int'(!cs));
    bus_read(1'b0, v);
    check("R6 master received byte", int'(v), int'(p));
    check("R12 irq cleared by data read", int'(irq), 0);
    bus_read(1'b1, v);
    check("R10 trf after byte", int'(v[0]), 1);
    if (col) check("R11 wcol cleared by control read", int'(v[1]), 0);
  endtask

  // Slave transfer driven by a bench-side master, SCLK half-period 8 clocks.
  task automatic s_xfer(input logic [7:0] d, input logic [7:0] p,
                        input logic msb, input logic cs);
    logic [7:0] cap, v;
    cap = '0;
    bus_write(1'b0, d);
    cs_n_in = cs ? 1'b0 : 1'b1;
    sdi = msb ? p[7] : p[0];
    repeat (8) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b1;
      cap[msb ? 7 - i : i] = sdo;
      repeat (8) @(negedge clk);
      sclk_in = 1'b0;
      if (i < 7) begin
        sdi = msb ? p[6 - i] : p[i + 1];
        repeat (8) @(negedge clk);
      end else begin
        repeat (2) @(negedge clk);
        check("R8 slave flag not yet set", int'(irq), 0);
        @(negedge clk);
        check("R8 slave flag on third edge", int'(irq), 1);
      end
    end
    cs_n_in = 1'b1;
    check("R6 slave sent bits in order", int'(cap), int'(d));
    bus_read(1'b0, v);
    check("R6 slave received byte", int'(v), int'(p));
    check("R12 irq cleared after slave read", int'(irq), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, d, p;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; irq_en = 1;
    sclk_in = 0; cs_n_in = 1; sdi = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(1'b1, v); check("R1 control reset", int'(v), 0);
    bus_read(1'b0, v); check("R1 data reset", int'(v), 0);
    check("R1 irq reset", int'(irq), 0);
    check("R1 sclk_out reset", int'(sclk_out), 0);
    check("R1 cs_n_out reset", int'(cs_n_out), 1);

    // R2 disabled block
    bus_write(1'b0, 8'h3C);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sclk_out !== 1'b0) check("R2 sclk idle while disabled", int'(sclk_out), 0);
    end
    check("R2 no irq while disabled", int'(irq), 0);
    bus_read(1'b1, v); check("R2 trf low while disabled", int'(v[0]), 0);
    bus_read(1'b0, v); check("R2 data still stored", int'(v), 8'h3C);

    // R3 control layout
    bus_write(1'b1, 8'hFF);
    bus_read(1'b1, v); check("R3 control readback", int'(v), 8'h7D);
    bus_write(1'b1, 8'h00);
    bus_read(1'b1, v); check("R3 control cleared", int'(v), 8'h00);

    // R4 R5 R6 R7 master sweep at the fast rate
    for (int b = 0; b < 16; b++) begin
      for (int o = 0; o < 2; o++) begin
        d = 8'(b * 37 + 8'h5A);
        p = 8'(~(b * 19) ^ (o * 8'hA5));
        bus_write(1'b1, mk_ctrl(2'b00, 1'b1, o[0], b[0]));
        m_xfer(d, p, 4, o[0], b[0], 1'b0);
      end
    end
    // R4 other master rates
    bus_write(1'b1, mk_ctrl(2'b01, 1'b1, 1'b1, 1'b1));
    m_xfer(8'hA6, 8'h3B, 16, 1'b1, 1'b1, 1'b0);
    bus_write(1'b1, mk_ctrl(2'b10, 1'b1, 1'b0, 1'b0));
    m_xfer(8'h1E, 8'hC4, 64, 1'b0, 1'b0, 1'b0);

    // R11 collision
    bus_write(1'b1, mk_ctrl(2'b00, 1'b1, 1'b1, 1'b1));
    m_xfer(8'h96, 8'h71, 4, 1'b1, 1'b1, 1'b1);

    // R12 irq gating
    irq_en = 1'b0;
    bus_write(1'b0, 8'h55);
    repeat (80) @(negedge clk);
    check("R12 irq masked", int'(irq), 0);
    irq_en = 1'b1;
    #1 check("R12 flag shown when enabled", int'(irq), 1);
    bus_write(1'b1, mk_ctrl(2'b00, 1'b0, 1'b1, 1'b0));
    bus_write(1'b0, 8'h00);
    check("R12 irq cleared by data write", int'(irq), 0);

    // R8 R9 slave sweep
    for (int b = 0; b < 8; b++) begin
      for (int o = 0; o < 2; o++) begin
        d = 8'(b * 29 + 8'h13);
        p = 8'(b * 53 ^ 8'hC9 ^ (o * 8'h3C));
        bus_write(1'b1, mk_ctrl(2'b11, 1'b1, o[0], b[1]));
        s_xfer(d, p, o[0], b[1]);
      end
    end

    // R9 deselected slave ignores SCLK
    bus_write(1'b1, mk_ctrl(2'b11, 1'b1, 1'b1, 1'b1));
    bus_write(1'b0, 8'h81);
    cs_n_in = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b1; sdi = i[0];
      repeat (8) @(negedge clk);
      sclk_in = 1'b0;
      repeat (8) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check("R9 no irq when deselected", int'(irq), 0);
    bus_read(1'b0, v); check("R9 data kept when deselected", int'(v), 8'h81);
    bus_read(1'b1, v); check("R10 trf idle slave", int'(v[0]), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule